// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single counter channel for an interval timer. It runs from the system clock and advances only in cycles where a one-cycle `tick` enable is high. A load strobe supplies a 16-bit reload value and a 3-bit mode together, and counting restarts from zero elapsed ticks. From then on the channel drives an output level whose waveform depends on the mode, and it presents the count that software would see.

Six behaviours are available: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square-wave generator, and two single-pulse strobes (one started by software, one also restartable from the gate). A reload of zero stands for 65536. In the modes that respond to the gate, a rising edge on the `gate` input restarts the count. A snapshot request copies the visible count into a holding register so that it can be read while counting goes on.

Top module: `interval_chan`

## Requirements
- R1: After reset the channel is in square-wave mode with a reload of 65536: `out_level` is 1 and `count_now` is 0. The remembered gate level after reset is high for channel index 0 or 1 and low for index 2, so on index 0 a gate held high through reset causes no restart, and a tick in the first cycle after reset gives a count of 65534.
- R2: A reload value of 0 acts as 65536 (in mode 0 the visible count is 0 and then 65535 after one tick). Any load sets the elapsed tick count d to 0.
- R3: Mode 0: `out_level` is 0 while d < reload and is 1 from the tick where d reaches the reload. It stays 1 after that.
- R4: Mode 1: `out_level` is 1 while d < reload, then 0 until the next restart or load.
- R5: Mode 2: the period is the reload value. `out_level` is 1 for one tick whenever d is a nonzero multiple of the reload, and `count_now` = (reload − d mod reload) mod 65536.
- R6: Mode 3: within each period, `out_level` is 1 while (d mod reload) < (reload+1)/2 and 0 otherwise. `count_now` = (reload − (2·d mod reload)) mod 65536, so it falls by two per tick.
- R7: Modes 4 and 5: `out_level` is 1 only while d equals the reload. That single pulse is never repeated.
- R8: A rising edge of `gate` sets d to 0 in modes 1, 2, 3 and 5. In modes 0 and 4 it has no effect.
- R9: In modes 0, 1, 4 and 5, `count_now` = (reload − d) mod 65536. It keeps wrapping below zero.
- R10: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R11: In one cycle, a load takes priority over both a gate edge and a tick (d becomes 0). A gate restart takes priority over a tick in the same cycle.
- R12: A `snap_req` copies the `count_now` of that cycle into `snap_count`, visible from the next cycle. `snap_count` holds until the next request and is 0 after reset.
- R13: In a cycle without tick, load or gate restart, the count and output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one cycle per counter step |
| load | input | 1 | Load strobe for reload value and mode |
| load_value | input | 16 | Reload value (0 means 65536) |
| load_mode | input | 3 | Counting mode code 0 to 7 |
| gate | input | 1 | Gate level, rising edge restarts in modes 1, 2, 3, 5 |
| snap_req | input | 1 | Snapshot request for the visible count |
| out_level | output | 1 | Channel output level |
| count_now | output | 16 | Current visible count |
| snap_count | output | 16 | Last captured count |

## Verification
Three events can coincide in one cycle: a tick, a gate rising edge and a load. The bench creates each collision on purpose. It issues a load together with a tick, a load together with a gate rising edge and a tick, and a gate rising edge together with a tick in a gate-restartable mode. It then checks `count_now` and `out_level` in the following cycles against a model that applies load first, then restart, then tick. A tick that wrongly slipped through would appear as a count one step (or two in square-wave mode) below the expected value.

// File: rtl/ichan_pkg.sv
// Package: shared mode type and mode classification helpers for the
// interval counter channel. Assumes a 3-bit mode code from the loader.
package ichan_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,  // flag on terminal count
        MD_ONESHOT = 3'd1,  // gate-triggered one-shot
        MD_RATE    = 3'd2,  // periodic single-tick pulse
        MD_SQUARE  = 3'd3,  // periodic square wave
        MD_SWSTB   = 3'd4,  // software-started strobe
        MD_HWSTB   = 3'd5   // gate-restartable strobe
    } cmode_e;

    // Map the raw code to a supported mode; codes 6 and 7 alias 2 and 3.
    function automatic cmode_e fold_mode(input logic [2:0] raw);
        case (raw)
            3'd6:    return MD_RATE;
            3'd7:    return MD_SQUARE;
            default: return cmode_e'(raw);
        endcase
    endfunction

    // Periodic modes wrap their phase at the reload value.
    function automatic logic is_periodic(input cmode_e m);
        return (m == MD_RATE) || (m == MD_SQUARE);
    endfunction

    // Modes in which a gate rising edge restarts counting.
    function automatic logic gate_retrig(input cmode_e m);
        return (m == MD_ONESHOT) || (m == MD_RATE) ||
               (m == MD_SQUARE)  || (m == MD_HWSTB);
    endfunction

endpackage

// File: rtl/ichan_cfg.sv
// Module: configuration registers and gate edge detection.
// Holds reload value (zero expanded to 2**CW) and folded mode; produces
// a restart pulse on a gate rising edge when the mode allows it and no
// load is present in the same cycle. Assumes inputs synchronous to clk.
module ichan_cfg
    import ichan_pkg::*;
#(
    parameter int  CW       = 16,
    parameter logic GATE_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_value,
    input  logic [2:0]    load_mode,
    input  logic          gate,
    output logic [CW:0]   reload,
    output cmode_e        mode,
    output logic          restart
);
    localparam int RW = CW + 1;
    localparam logic [RW-1:0] FULL = {1'b1, {CW{1'b0}}};

    logic gate_q;

    // Capture reload value and mode on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= FULL;
            mode   <= MD_SQUARE;
        end else if (load) begin
            reload <= (load_value == '0) ? FULL : {1'b0, load_value};
            mode   <= fold_mode(load_mode);
        end
    end

    // Remember the previous gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= GATE_RST;
        else        gate_q <= gate;
    end

    assign restart = gate & ~gate_q & ~load & gate_retrig(mode);

    assert_zero_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_value == '0) |=> (reload == FULL));

    assert_reload_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (reload != '0));

endmodule

// File: rtl/ichan_phase.sv
// Module: elapsed-tick state of the channel.
// ph is the position inside the period (periodic modes wrap at reload,
// other modes saturate at reload+1); ew is a free-running 16-bit elapsed
// count used for the wrapping visible count; started marks d != 0.
// Assumes clear already merges load and gate restart.
module ichan_phase
    import ichan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic [CW:0]   reload,
    input  cmode_e        mode,
    output logic [CW+1:0] ph,
    output logic [CW-1:0] ew,
    output logic          started
);
    localparam int PW = CW + 2;

    logic [PW-1:0] ph_inc;
    logic [PW-1:0] reload_x;

    assign ph_inc   = ph + 1'b1;
    assign reload_x = {1'b0, reload};

    // Advance phase, elapsed count and started flag on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ph      <= '0;
            ew      <= '0;
            started <= 1'b0;
        end else if (tick) begin
            started <= 1'b1;
            ew      <= ew + 1'b1;
            if (is_periodic(mode)) begin
                ph <= (ph_inc == reload_x) ? '0 : ph_inc;
            end else if (ph <= reload_x) begin
                ph <= ph_inc;
            end
        end
    end

    assert_periodic_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_periodic(mode) |-> (ph < reload_x));

    assert_sat_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !is_periodic(mode) |-> (ph <= reload_x + 1'b1));

    assert_freeze_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> ($stable(ph) && $stable(ew)));

endmodule

// File: rtl/ichan_view.sv
// Module: combinational decode of output level and visible count from
// the registered phase state. Assumes ph < reload in periodic modes and
// ph <= reload+1 otherwise.
module ichan_view
    import ichan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW:0]   reload,
    input  cmode_e        mode,
    input  logic [CW+1:0] ph,
    input  logic [CW-1:0] ew,
    input  logic          started,
    output logic          out_level,
    output logic [CW-1:0] count_now
);
    localparam int RW = CW + 1;
    localparam int PW = CW + 2;

    logic [PW-1:0] reload_x;
    logic [PW-1:0] half;
    logic [PW-1:0] twice;
    logic [PW-1:0] fold;
    logic [PW-1:0] sq_cnt;
    logic [RW-1:0] rate_cnt;

    assign reload_x = {1'b0, reload};
    assign half     = (reload_x + 1'b1) >> 1;
    assign twice    = {ph[RW-1:0], 1'b0};
    assign fold     = (twice >= reload_x) ? (twice - reload_x) : twice;
    assign sq_cnt   = reload_x - fold;
    assign rate_cnt = reload - ph[RW-1:0];

    // Select the output level and visible count for the active mode.
    always_comb begin
        case (mode)
            MD_TERM: begin
                out_level = (ph >= reload_x);
                count_now = reload[CW-1:0] - ew;
            end
            MD_ONESHOT: begin
                out_level = (ph < reload_x);
                count_now = reload[CW-1:0] - ew;
            end
            MD_RATE: begin
                out_level = (ph == '0) && started;
                count_now = rate_cnt[CW-1:0];
            end
            MD_SQUARE: begin
                out_level = (ph < half);
                count_now = sq_cnt[CW-1:0];
            end
            default: begin
                out_level = (ph == reload_x);
                count_now = reload[CW-1:0] - ew;
            end
        endcase
    end

endmodule

// File: rtl/interval_chan.sv
// Module: top of one interval counter channel.
// Wires configuration, phase state and view decode, and holds the
// snapshot register. CHAN_IDX selects the gate level assumed at reset.
module interval_chan
    import ichan_pkg::*;
#(
    parameter int CW       = 16,
    parameter int CHAN_IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_value,
    input  logic [2:0]    load_mode,
    input  logic          gate,
    input  logic          snap_req,
    output logic          out_level,
    output logic [CW-1:0] count_now,
    output logic [CW-1:0] snap_count
);
    localparam logic GATE_RST = (CHAN_IDX != 2);

    logic [CW:0]   reload;
    cmode_e        mode;
    logic          restart;
    logic [CW+1:0] ph;
    logic [CW-1:0] ew;
    logic          started;

    ichan_cfg #(.CW(CW), .GATE_RST(GATE_RST)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_value (load_value),
        .load_mode  (load_mode),
        .gate       (gate),
        .reload     (reload),
        .mode       (mode),
        .restart    (restart)
    );

    ichan_phase #(.CW(CW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (load | restart),
        .reload  (reload),
        .mode    (mode),
        .ph      (ph),
        .ew      (ew),
        .started (started)
    );

    ichan_view #(.CW(CW)) u_view (
        .reload    (reload),
        .mode      (mode),
        .ph        (ph),
        .ew        (ew),
        .started   (started),
        .out_level (out_level),
        .count_now (count_now)
    );

    // Capture the visible count on a snapshot request.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_count <= '0;
        else if (snap_req) snap_count <= count_now;
    end

    assert_snap_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap_count == $past(count_now)));

    assert_term_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TERM && out_level && !load) |=> out_level);

    assert_oneshot_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ONESHOT && !out_level && !load && !restart) |=> !out_level);

endmodule

// File: tb/tb_interval_chan.sv
// Scoreboard bench: the step task drives one cycle, advances a reference
// model built on elapsed ticks, and pushes the expected outputs; the
// monitor pops and compares them after each rising edge.
module tb_interval_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_value = '0;
    logic [2:0]  load_mode = '0;
    logic        gate = 1'b1;
    logic        snap_req = 1'b0;
    logic        out_level;
    logic [15:0] count_now;
    logic [15:0] snap_count;

    always #4 clk = ~clk;  // 125 MHz

    interval_chan dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .load_value (load_value),
        .load_mode  (load_mode),
        .gate       (gate),
        .snap_req   (snap_req),
        .out_level  (out_level),
        .count_now  (count_now),
        .snap_count (snap_count)
    );

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic        o;
        logic [15:0] snap;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   g_lvl = 1'b1;

    longint m_r = 65536;
    longint m_d = 0;
    int     m_m = 3;
    bit     m_gprev = 1'b1;
    logic [15:0] m_snap = '0;

    function automatic logic [15:0] exp_count();
        longint v;
        case (m_m)
            2:       v = m_r - (m_d % m_r);
            3:       v = m_r - ((2 * m_d) % m_r);
            default: v = m_r - m_d;
        endcase
        return 16'(v & 65535);
    endfunction

    function automatic logic exp_out();
        case (m_m)
            0:       return m_d >= m_r;
            1:       return m_d < m_r;
            2:       return (m_d % m_r == 0) && (m_d != 0);
            3:       return (m_d % m_r) < ((m_r + 1) / 2);
            default: return m_d == m_r;
        endcase
    endfunction

    task automatic step(input string tag, input bit rs, input bit ld,
                        input logic [15:0] v, input logic [2:0] md,
                        input bit g, input bit tk, input bit sn);
        exp_t e;
        @(negedge clk);
        rst_n = rs; load = ld; load_value = v; load_mode = md;
        gate = g; tick = tk; snap_req = sn;
        if (!rs) begin
            m_r = 65536; m_m = 3; m_d = 0; m_gprev = 1'b1; m_snap = '0;
        end else begin
            if (sn) m_snap = exp_count();
            if (ld) begin
                m_r = (v == 0) ? 65536 : longint'(v);
                m_m = (md >= 6) ? int'(md) - 4 : int'(md);
                m_d = 0;
            end else if (g && !m_gprev && (m_m == 1 || m_m == 2 || m_m == 3 || m_m == 5)) begin
                m_d = 0;
            end else if (tk) begin
                m_d = m_d + 1;
            end
            m_gprev = g;
        end
        e.tag = tag; e.cnt = exp_count(); e.o = exp_out(); e.snap = m_snap;
        q.push_back(e);
    endtask

    task automatic run(input string tag, input int n, input bit tk);
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 16'd0, 3'd0, g_lvl, tk, 1'b0);
    endtask

    task automatic ld(input string tag, input logic [15:0] v, input logic [2:0] md);
        step(tag, 1'b1, 1'b1, v, md, g_lvl, 1'b0, 1'b0);
    endtask

    task automatic gate_pulse(input string tag, input bit tk);
        g_lvl = 1'b0; run(tag, 1, 1'b0);
        g_lvl = 1'b1; run(tag, 1, tk);
    endtask

    // Monitor: compare outputs with the expected item after each edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (count_now !== e.cnt) begin
                errors++;
                $display("FAIL %s count_now actual %0d expected %0d", e.tag, count_now, e.cnt);
            end
            checks++;
            if (out_level !== e.o) begin
                errors++;
                $display("FAIL %s out_level actual %0b expected %0b", e.tag, out_level, e.o);
            end
            checks++;
            if (snap_count !== e.snap) begin
                errors++;
                $display("FAIL %s snap_count actual %0d expected %0d", e.tag, snap_count, e.snap);
            end
        end
    end

    initial begin
        // R1: reset state, default gate memory, first-cycle tick
        for (int i = 0; i < 3; i++) step("R1", 1'b0, 1'b0, 16'd0, 3'd0, 1'b1, 1'b0, 1'b0);
        run("R1", 1, 1'b1);
        run("R6", 3, 1'b1);
        // R13: no tick, nothing moves
        run("R13", 3, 1'b0);
        // R3 / R9: terminal count with wrap below zero; R8: gate ignored
        ld("R3", 16'd5, 3'd0);
        run("R3", 5, 1'b1);
        run("R9", 3, 1'b1);
        gate_pulse("R8", 1'b1);
        run("R9", 1, 1'b1);
        // R2: zero reload
        ld("R2", 16'd0, 3'd0);
        run("R2", 2, 1'b1);
        // R4: one-shot, gate restart colliding with tick (R11)
        ld("R4", 16'd4, 3'd1);
        run("R4", 5, 1'b1);
        gate_pulse("R11", 1'b1);
        run("R8", 3, 1'b1);
        // R5: rate generator
        ld("R5", 16'd3, 3'd2);
        run("R5", 7, 1'b1);
        run("R5", 2, 1'b0);
        run("R5", 2, 1'b1);
        ld("R5", 16'd1, 3'd2);
        run("R5", 3, 1'b1);
        ld("R5", 16'd4, 3'd2);
        run("R5", 2, 1'b1);
        gate_pulse("R11", 1'b1);
        run("R5", 5, 1'b1);
        // R6: square wave, odd and even reload
        ld("R6", 16'd5, 3'd3);
        run("R6", 11, 1'b1);
        ld("R6", 16'd6, 3'd3);
        run("R6", 4, 1'b1);
        gate_pulse("R8", 1'b0);
        run("R6", 7, 1'b1);
        // R7: strobes; gate ignored in mode 4, restarts in mode 5
        ld("R7", 16'd3, 3'd4);
        run("R7", 6, 1'b1);
        gate_pulse("R8", 1'b0);
        run("R7", 2, 1'b1);
        ld("R7", 16'd2, 3'd5);
        run("R7", 2, 1'b1);
        gate_pulse("R8", 1'b0);
        run("R7", 4, 1'b1);
        // R10: aliased mode codes
        ld("R10", 16'd4, 3'd6);
        run("R10", 6, 1'b1);
        ld("R10", 16'd3, 3'd7);
        run("R10", 5, 1'b1);
        // R11: load beats tick; load beats gate edge and tick
        run("R11", 2, 1'b1);
        step("R11", 1'b1, 1'b1, 16'd4, 3'd2, 1'b1, 1'b1, 1'b0);
        run("R11", 2, 1'b1);
        g_lvl = 1'b0; run("R11", 1, 1'b0);
        step("R11", 1'b1, 1'b1, 16'd3, 3'd1, 1'b1, 1'b1, 1'b0);
        g_lvl = 1'b1;
        run("R11", 4, 1'b1);
        // R12: snapshot capture and hold
        ld("R12", 16'd100, 3'd0);
        run("R12", 3, 1'b1);
        step("R12", 1'b1, 1'b0, 16'd0, 3'd0, 1'b1, 1'b1, 1'b1);
        run("R12", 3, 1'b1);
        step("R12", 1'b1, 1'b0, 16'd0, 3'd0, 1'b1, 1'b0, 1'b1);
        run("R12", 2, 1'b1);
        // drain the scoreboard
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule